// File: doc/BRIEF.md
# One-Bit Modulator Capture and Density Monitor

This block sits between up to four external one-bit delta-sigma modulators and the decimation filters that follow them. It generates the shared clocks the modulators run from: a full-rate clock, a clock at half that rate, and a resynchronisation pulse. The pulse is issued whenever the system raises its sync request, and it restarts the clock divider so that every modulator and every capture channel begins again in step.

Each channel samples its modulator's bitstream once per full-rate clock period, on the rising edge. It turns the bit into a signed two-bit sample (+1 for a one, -1 for a zero) with a one-cycle valid strobe for the next filter stage. A modulator that runs at half the rate needs no separate capture mode, because each of its bits is simply sampled twice. Each channel also counts ones over a window of 2^N samples. At the end of the window it compares the count with the full-scale band (14 % to 86 % ones) and the wider overhang band (7 % to 93 %). A count outside either band sets a sticky status bit. A modulator's instability flag is latched as a sticky bit as well. Sticky bits are cleared only by the clear input or by reset.

Top module: `dsm_front_end`

## Requirements
- R1: With `rate_slow` low, `mod_clk` has a period of 2*HALF_CYC `clk` cycles. With it high, the period is 4*HALF_CYC cycles. `mod_clk_half` toggles only on rising edges of `mod_clk`, so its period is twice that of `mod_clk`.
- R2: A rising edge on `sync_req` drives `mod_clk` and `mod_clk_half` low and restarts the divider. It also raises `mod_sync` for exactly one `mod_clk` period of `clk` cycles.
- R3: Every channel samples `mod_data[i]` once per `mod_clk` period, at the rising edge. It then presents `smp_data[2i+1:2i]` as two's complement: 2'b01 (+1) for a one, 2'b11 (-1) for a zero. `smp_valid[i]` is high for exactly one `clk` cycle per sample.
- R4: The density window is 2^N samples long. N is `win_log` limited to the range WIN_MIN to WIN_MAX, so values below WIN_MIN act as WIN_MIN. A window starts with the first sample after a sync.
- R5: At the end of a window with K ones, `fs_sticky[i]` is set if K*100 > 86*2^N or K*100 < 14*2^N.
- R6: At the end of a window, `range_sticky[i]` is set if K*100 > 93*2^N or K*100 < 7*2^N. Whenever `range_sticky[i]` is set, `fs_sticky[i]` is set too.
- R7: `err_sticky[i]` is set when `mod_err[i]` is high at a sample instant.
- R8: Sticky bits hold until `clear` is pulsed or reset is applied. `clear` zeroes every sticky bit of every channel. A window that ends in band leaves the sticky bits unchanged.
- R9: A change of `win_log` during a window has no effect until the next window begins.
- R10: A sync discards any partly counted window. Samples taken before it do not count toward the next status decision.
- R11: While reset is held, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_slow | input | 1 | 1 doubles the modulator clock period |
| win_log | input | WLW | Density window exponent N |
| sync_req | input | 1 | Resynchronisation request (rising edge acts) |
| clear | input | 1 | Clears all sticky status bits |
| mod_data | input | NCH | Modulator bitstreams, one per channel |
| mod_err | input | NCH | Modulator instability flags |
| mod_clk | output | 1 | Full-rate modulator clock |
| mod_clk_half | output | 1 | Half-rate modulator clock |
| mod_sync | output | 1 | Modulator resynchronisation pulse |
| smp_data | output | 2*NCH | Signed samples, two bits per channel |
| smp_valid | output | NCH | Sample strobes |
| err_sticky | output | NCH | Latched instability flags |
| fs_sticky | output | NCH | Latched beyond-full-scale status |
| range_sticky | output | NCH | Latched out-of-overhang status |

## Verification
A divider count that drifts shows up within one `mod_clk` period as a wrong edge spacing on `mod_clk` or `mod_clk_half`. A wrong capture phase shows up on the very next valid strobe as a sample that disagrees with the driven bit. A ones counter or window-length register that is off by one can hide for an entire window. It becomes visible only at the window end, as a wrong sticky bit, and only when the count lies near a threshold. The sweep therefore gives every ones count from 0 to 2^N to some channel, and it uses syncs, clamping and mid-window changes of N to expose stale window state.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  typedef logic signed [1:0] smp_t;
  localparam smp_t SMP_POS = 2'sb01;
  localparam smp_t SMP_NEG = 2'sb11;
  localparam int PCT_FS_LO = 14;
  localparam int PCT_FS_HI = 86;
  localparam int PCT_OH_LO = 7;
  localparam int PCT_OH_HI = 93;
endpackage

// File: rtl/dsm_clkgen.sv
module dsm_clkgen #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rate_slow,
  input  logic sync_req,
  output logic mod_clk,
  output logic mod_clk_half,
  output logic mod_sync,
  output logic tick,
  output logic realign
);
  localparam int CW = $clog2(4 * HALF_CYC + 1) + 1;

  logic [CW-1:0] half_len;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW:0]   ms_q, ms_d;
  logic mclk_q, mclk_d;
  logic mhalf_q, mhalf_d;
  logic msync_q, msync_d;
  logic tick_q, tick_d;
  logic realign_q, realign_d;
  logic sync_q;
  logic sync_edge;

  assign half_len  = rate_slow ? CW'(2 * HALF_CYC) : CW'(HALF_CYC);
  assign sync_edge = sync_req & ~sync_q;

  always_comb begin
    cnt_d     = cnt_q;
    mclk_d    = mclk_q;
    mhalf_d   = mhalf_q;
    msync_d   = msync_q;
    ms_d      = ms_q;
    tick_d    = 1'b0;
    realign_d = 1'b0;
    if (sync_edge) begin
      cnt_d     = '0;
      mclk_d    = 1'b0;
      mhalf_d   = 1'b0;
      msync_d   = 1'b1;
      ms_d      = {half_len, 1'b0} - 1'b1;
      realign_d = 1'b1;
    end else begin
      if (cnt_q >= half_len - 1'b1) begin
        cnt_d  = '0;
        mclk_d = ~mclk_q;
        if (!mclk_q) begin
          mhalf_d = ~mhalf_q;
          tick_d  = 1'b1;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      if (msync_q) begin
        if (ms_q == '0) msync_d = 1'b0;
        else            ms_d    = ms_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      ms_q      <= '0;
      mclk_q    <= 1'b0;
      mhalf_q   <= 1'b0;
      msync_q   <= 1'b0;
      tick_q    <= 1'b0;
      realign_q <= 1'b0;
      sync_q    <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      ms_q      <= ms_d;
      mclk_q    <= mclk_d;
      mhalf_q   <= mhalf_d;
      msync_q   <= msync_d;
      tick_q    <= tick_d;
      realign_q <= realign_d;
      sync_q    <= sync_req;
    end
  end

  assign mod_clk      = mclk_q;
  assign mod_clk_half = mhalf_q;
  assign mod_sync     = msync_q;
  assign tick         = tick_q;
  assign realign      = realign_q;
endmodule

// File: rtl/dsm_chan.sv
module dsm_chan
  import dsm_pkg::*;
#(
  parameter int WIN_MIN = 2,
  parameter int WIN_MAX = 10,
  parameter int WLW     = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           realign,
  input  logic           clear,
  input  logic [WLW-1:0] win_log,
  input  logic           bit_in,
  input  logic           err_in,
  output smp_t           smp,
  output logic           smp_vld,
  output logic           err_st,
  output logic           fs_st,
  output logic           rng_st
);
  localparam int CNTW = WIN_MAX + 1;
  localparam int NW   = $clog2(WIN_MAX + 1);
  localparam int PW   = CNTW + 8;

  logic [NW-1:0]   n_req, n_eff, n_q, n_d;
  logic [CNTW-1:0] cnt_q, cnt_d, ones_q, ones_d, ones_nx, len_m1;
  logic [PW-1:0]   prod, thr_fs_lo, thr_fs_hi, thr_oh_lo, thr_oh_hi;
  logic            win_end, beyond_fs, beyond_oh;
  smp_t            smp_q, smp_d;
  logic            vld_q, vld_d;
  logic            err_q, err_d, fs_q, fs_d, rng_q, rng_d;

  always_comb begin
    if (int'(win_log) < WIN_MIN)      n_req = NW'(WIN_MIN);
    else if (int'(win_log) > WIN_MAX) n_req = NW'(WIN_MAX);
    else                              n_req = NW'(win_log);
  end

  assign n_eff     = (cnt_q == '0) ? n_req : n_q;
  assign len_m1    = (CNTW'(1) << n_eff) - 1'b1;
  assign ones_nx   = ones_q + CNTW'(bit_in);
  assign prod      = PW'(ones_nx) * PW'(100);
  assign thr_fs_lo = PW'(PCT_FS_LO) << n_eff;
  assign thr_fs_hi = PW'(PCT_FS_HI) << n_eff;
  assign thr_oh_lo = PW'(PCT_OH_LO) << n_eff;
  assign thr_oh_hi = PW'(PCT_OH_HI) << n_eff;
  assign beyond_fs = (prod > thr_fs_hi) || (prod < thr_fs_lo);
  assign beyond_oh = (prod > thr_oh_hi) || (prod < thr_oh_lo);
  assign win_end   = tick && (cnt_q == len_m1);

  always_comb begin
    cnt_d  = cnt_q;
    ones_d = ones_q;
    n_d    = n_q;
    smp_d  = smp_q;
    vld_d  = 1'b0;
    err_d  = clear ? 1'b0 : err_q;
    fs_d   = clear ? 1'b0 : fs_q;
    rng_d  = clear ? 1'b0 : rng_q;
    if (realign) begin
      cnt_d  = '0;
      ones_d = '0;
    end else if (tick) begin
      vld_d = 1'b1;
      smp_d = bit_in ? SMP_POS : SMP_NEG;
      n_d   = n_eff;
      if (err_in) err_d = 1'b1;
      if (win_end) begin
        cnt_d  = '0;
        ones_d = '0;
        if (beyond_fs || beyond_oh) fs_d = 1'b1;
        if (beyond_oh)              rng_d = 1'b1;
      end else begin
        cnt_d  = cnt_q + 1'b1;
        ones_d = ones_nx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ones_q <= '0;
      n_q    <= '0;
      smp_q  <= '0;
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
      fs_q   <= 1'b0;
      rng_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      ones_q <= ones_d;
      n_q    <= n_d;
      smp_q  <= smp_d;
      vld_q  <= vld_d;
      err_q  <= err_d;
      fs_q   <= fs_d;
      rng_q  <= rng_d;
    end
  end

  assign smp     = smp_q;
  assign smp_vld = vld_q;
  assign err_st  = err_q;
  assign fs_st   = fs_q;
  assign rng_st  = rng_q;
endmodule

// File: rtl/dsm_front_end.sv
module dsm_front_end
  import dsm_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int HALF_CYC = 2,
  parameter int WIN_MIN  = 2,
  parameter int WIN_MAX  = 10,
  parameter int WLW      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rate_slow,
  input  logic [WLW-1:0]   win_log,
  input  logic             sync_req,
  input  logic             clear,
  input  logic [NCH-1:0]   mod_data,
  input  logic [NCH-1:0]   mod_err,
  output logic             mod_clk,
  output logic             mod_clk_half,
  output logic             mod_sync,
  output logic [2*NCH-1:0] smp_data,
  output logic [NCH-1:0]   smp_valid,
  output logic [NCH-1:0]   err_sticky,
  output logic [NCH-1:0]   fs_sticky,
  output logic [NCH-1:0]   range_sticky
);
  logic [1:0] rst_pipe;
  logic       rst_i;
  logic       tick;
  logic       realign;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i = rst_pipe[1];

  dsm_clkgen #(.HALF_CYC(HALF_CYC)) u_clkgen (
    .clk          (clk),
    .rst_n        (rst_i),
    .rate_slow    (rate_slow),
    .sync_req     (sync_req),
    .mod_clk      (mod_clk),
    .mod_clk_half (mod_clk_half),
    .mod_sync     (mod_sync),
    .tick         (tick),
    .realign      (realign)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    smp_t s;
    dsm_chan #(.WIN_MIN(WIN_MIN), .WIN_MAX(WIN_MAX), .WLW(WLW)) u_chan (
      .clk     (clk),
      .rst_n   (rst_i),
      .tick    (tick),
      .realign (realign),
      .clear   (clear),
      .win_log (win_log),
      .bit_in  (mod_data[g]),
      .err_in  (mod_err[g]),
      .smp     (s),
      .smp_vld (smp_valid[g]),
      .err_st  (err_sticky[g]),
      .fs_st   (fs_sticky[g]),
      .rng_st  (range_sticky[g])
    );
    assign smp_data[2*g +: 2] = s;
  end
endmodule

// File: rtl/dsm_front_end_chk.sv
module dsm_front_end_chk #(
  parameter int NCH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear,
  input logic             mod_clk,
  input logic             mod_clk_half,
  input logic             mod_sync,
  input logic [2*NCH-1:0] smp_data,
  input logic [NCH-1:0]   smp_valid,
  input logic [NCH-1:0]   err_sticky,
  input logic [NCH-1:0]   fs_sticky,
  input logic [NCH-1:0]   range_sticky
);
  a_r1_half_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mod_clk_half) && !mod_sync) |-> $rose(mod_clk));

  a_r2_sync_clocks_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_sync) |-> (!mod_clk && !mod_clk_half));

  a_r6_range_within_fs: assert property (@(posedge clk) disable iff (!rst_n)
    (range_sticky & ~fs_sticky) == '0);

  for (genvar i = 0; i < NCH; i++) begin : g_a
    a_r3_sample_code: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid[i] |-> (smp_data[2*i +: 2] == 2'b01 || smp_data[2*i +: 2] == 2'b11));
    a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid[i] |=> !smp_valid[i]);
    a_r8_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (err_sticky[i] && !clear) |=> err_sticky[i]);
    a_r8_fs_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (fs_sticky[i] && !clear) |=> fs_sticky[i]);
    a_r8_range_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (range_sticky[i] && !clear) |=> range_sticky[i]);
  end
endmodule

bind dsm_front_end dsm_front_end_chk #(.NCH(NCH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .clear        (clear),
  .mod_clk      (mod_clk),
  .mod_clk_half (mod_clk_half),
  .mod_sync     (mod_sync),
  .smp_data     (smp_data),
  .smp_valid    (smp_valid),
  .err_sticky   (err_sticky),
  .fs_sticky    (fs_sticky),
  .range_sticky (range_sticky)
);

// File: tb/dsm_front_end_test.sv
module dsm_front_end_test;
  localparam int CLK_PER  = 10;
  localparam int NCH      = 4;
  localparam int HALF_CYC = 2;
  localparam int WIN_MIN  = 2;
  localparam int WIN_MAX  = 10;
  localparam int WLW      = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             rate_slow;
  logic [WLW-1:0]   win_log;
  logic             sync_req;
  logic             clear;
  logic [NCH-1:0]   mod_data;
  logic [NCH-1:0]   mod_err;
  logic             mod_clk, mod_clk_half, mod_sync;
  logic [2*NCH-1:0] smp_data;
  logic [NCH-1:0]   smp_valid, err_sticky, fs_sticky, range_sticky;

  int checks = 0;
  int errors = 0;
  logic mon_en = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  dsm_front_end #(.NCH(NCH), .HALF_CYC(HALF_CYC), .WIN_MIN(WIN_MIN),
                  .WIN_MAX(WIN_MAX), .WLW(WLW)) uut (
    .clk(clk), .rst_n(rst_n), .rate_slow(rate_slow), .win_log(win_log),
    .sync_req(sync_req), .clear(clear), .mod_data(mod_data), .mod_err(mod_err),
    .mod_clk(mod_clk), .mod_clk_half(mod_clk_half), .mod_sync(mod_sync),
    .smp_data(smp_data), .smp_valid(smp_valid), .err_sticky(err_sticky),
    .fs_sticky(fs_sticky), .range_sticky(range_sticky));

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R3: sample code checked against the driven bit at every strobe
  always @(negedge clk) begin
    if (mon_en) begin
      for (int i = 0; i < NCH; i++) begin
        if (smp_valid[i])
          check("R3 sample", smp_data[2*i +: 2], mod_data[i] ? 2'b01 : 2'b11);
      end
    end
  end

  function automatic int eff_n(input int w);
    if (w < WIN_MIN) return WIN_MIN;
    if (w > WIN_MAX) return WIN_MAX;
    return w;
  endfunction

  function automatic logic beyond(input int k, input int n, input int lo, input int hi);
    return (k * 100 > hi * (1 << n)) || (k * 100 < lo * (1 << n));
  endfunction

  task automatic pulse_clear();
    @(negedge clk) clear = 1'b1;
    @(negedge clk) clear = 1'b0;
  endtask

  task automatic do_sync();
    @(negedge clk) sync_req = 1'b1;
    @(negedge clk) sync_req = 1'b0;
  endtask

  // Run one aligned window: channel i gets k[i] ones first, then zeros.
  task automatic window(input int k [NCH], input int wl, input int wl_mid,
                        input logic [NCH-1:0] err0);
    int n;
    int len;
    n   = eff_n(wl);
    len = 1 << n;
    win_log = WLW'(wl);
    for (int i = 0; i < NCH; i++) mod_data[i] = (k[i] > 0);
    mod_err = err0;
    do_sync();
    for (int j = 0; j < len; j++) begin
      for (int i = 0; i < NCH; i++) mod_data[i] = (j < k[i]);
      if (j == len / 2) win_log = WLW'(wl_mid);
      @(negedge mod_clk);
      mod_err = '0;
    end
    @(negedge clk);
    win_log = WLW'(wl);
  endtask

  task automatic check_status(input int k [NCH], input int wl, input string tag);
    logic [NCH-1:0] efs, erg;
    int n;
    n = eff_n(wl);
    for (int i = 0; i < NCH; i++) begin
      erg[i] = beyond(k[i], n, 7, 93);
      efs[i] = beyond(k[i], n, 14, 86) | erg[i];
    end
    check({tag, " R5 fs_sticky"}, fs_sticky, efs);
    check({tag, " R6 range_sticky"}, range_sticky, erg);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int k [NCH];
    longint t0, t1, t2;
    rst_n = 1'b0; rate_slow = 1'b0; win_log = 4'd4; sync_req = 1'b0;
    clear = 1'b0; mod_data = '0; mod_err = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 clocks", {mod_clk, mod_clk_half, mod_sync}, 0);
    check("R11 samples", {smp_data, smp_valid}, 0);
    check("R11 status", {err_sticky, fs_sticky, range_sticky}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_en = 1'b1;

    // R1: clock periods at both rate settings
    for (int r = 0; r < 2; r++) begin
      rate_slow = r[0];
      do_sync();
      @(posedge mod_clk); t0 = $time;
      @(posedge mod_clk); t1 = $time;
      check("R1 mod_clk period", (t1 - t0) / CLK_PER, 2 * HALF_CYC * (r + 1));
      @(posedge mod_clk_half); t0 = $time;
      @(posedge mod_clk_half); t2 = $time;
      check("R1 mod_clk_half period", (t2 - t0) / CLK_PER, 4 * HALF_CYC * (r + 1));
    end

    // R2: sync forces clocks low and pulses mod_sync for one period
    for (int r = 0; r < 2; r++) begin
      int hi;
      rate_slow = r[0];
      @(posedge mod_clk);
      @(negedge clk) sync_req = 1'b1;
      @(negedge clk) sync_req = 1'b0;
      check("R2 clocks low", {mod_clk, mod_clk_half}, 0);
      hi = 0;
      while (mod_sync) begin hi++; @(negedge clk); end
      check("R2 sync length", hi, 2 * HALF_CYC * (r + 1));
    end
    rate_slow = 1'b0;
    pulse_clear();

    // R4 R5 R6: sweep every ones count 0..16 over a 16-sample window
    for (int w = 0; w < 5; w++) begin
      for (int i = 0; i < NCH; i++) k[i] = (w * NCH + i) % 17;
      pulse_clear();
      window(k, 4, 4, '0);
      check_status(k, 4, "R4 sweep");
    end

    // R4: exponent below minimum is clamped to WIN_MIN (window of 4)
    k = '{4, 0, 2, 3};
    pulse_clear();
    window(k, 0, 0, '0);
    check_status(k, 0, "R4 clamp");

    // R9: mid-window change of win_log is ignored
    k = '{15, 13, 2, 1};
    pulse_clear();
    window(k, 4, 2, '0);
    check_status(k, 4, "R9 midchange");

    // R8: in-band window keeps sticky bits, clear zeroes them
    k = '{8, 8, 8, 8};
    window(k, 4, 4, '0);
    check("R8 hold fs", fs_sticky, 4'b1101);
    check("R8 hold range", range_sticky, 4'b1001);
    pulse_clear();
    check("R8 clear", {fs_sticky, range_sticky}, 0);

    // R10: sync discards a partial window of all ones
    for (int i = 0; i < NCH; i++) mod_data[i] = 1'b1;
    do_sync();
    repeat (6) @(negedge mod_clk);
    k = '{8, 8, 8, 8};
    window(k, 4, 4, '0);
    check("R10 partial discarded", {fs_sticky, range_sticky}, 0);

    // R7: error flag latched per channel
    k = '{8, 8, 8, 8};
    window(k, 4, 4, 4'b0100);
    check("R7 err sticky", err_sticky, 4'b0100);
    pulse_clear();
    check("R7 err cleared", err_sticky, 0);

    // R3: half-rate stream gives each bit twice
    do_sync();
    for (int j = 0; j < 8; j++) begin
      mod_data = (j % 4 < 2) ? 4'b0101 : 4'b1010;
      @(negedge mod_clk);
    end

    mon_en = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule